// File: doc/BRIEF.md
# Inter-Processor Software Interrupt Unit

This unit lets any hart post a software interrupt to any other hart through a small memory-mapped register bank. Each hart owns one 32-bit register slot. Slots sit four bytes apart starting at offset zero, and only bit 0 of a slot carries meaning. The unit drives one interrupt line per hart. Each line comes straight from a pending flop.

A parameter selects one of two flavours. In the machine flavour a slot acts as a read/write pending bit: writing 1 raises the interrupt, writing 0 lowers it, and reads return the bit. In the supervisor flavour a slot is set-only: writes of 1 raise the interrupt, writes of 0 do nothing, and reads always return zero. The receiving hart retires the interrupt by pulsing its own clear input. The bus takes only full 32-bit accesses. Reads are combinational from the current pending state, and writes take effect at the next clock edge.

Top module: `swirq_unit`

## Requirements
- R1: Offset `o` addresses hart `o/4` only when `o[1:0]==0` and `o/4 < NUM_HARTS`. With 4 harts, offset 0x0C reaches hart 3 and offset 0x10 reaches no hart.
- R2: A write with `bus_wdata[0]==1` to a valid slot sets that hart's pending bit. `swi_irq[h]` is high after the next rising clock edge, in both flavours.
- R3: In the machine flavour (`SUPERVISOR_MODE==0`), a write with `bus_wdata[0]==0` to a valid slot clears that hart's pending bit at the next edge.
- R4: In the machine flavour, a read of a valid slot returns the pending bit in bit 0 and zeros in bits 31:1, in the same cycle.
- R5: In the supervisor flavour (`SUPERVISOR_MODE==1`), every read returns 0.
- R6: In the supervisor flavour, a write with `bus_wdata[0]==0` leaves all pending bits unchanged.
- R7: In the supervisor flavour, a one-cycle pulse on `hart_clr[h]` clears pending bit `h` at the next edge. When a set write to the same hart arrives in the same cycle, the set wins.
- R8: In the machine flavour, `hart_clr` has no effect on any pending bit.
- R9: While `rst_n` is low, every pending bit and every `swi_irq` line is 0.
- R10: A misaligned offset, or an offset at or beyond `4*NUM_HARTS`, reads as 0, and a write to it changes no pending bit.
- R11: Bits 31:1 of the write data are ignored. Writing 0xFFFFFFFE behaves exactly as writing 0, and writing 0xFFFFFFFF behaves exactly as writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the unit |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| hart_clr | input | NUM_HARTS | Per-hart clear pulse from the receiving hart (supervisor flavour) |
| swi_irq | output | NUM_HARTS | Per-hart software interrupt line |

## Verification
Read data is due in the same cycle as the read strobe. The bench drives each read just after a rising edge and samples `bus_rdata` at the following falling edge. Interrupt lines move one edge after the accepted write or clear pulse. The bench therefore holds each write or clear for exactly one edge and samples the lines at the falling edge after that edge. A behavioural model with one pending bit per hart for each flavour updates on every rising edge. The bench compares both instances against this model at every falling edge, and directed checks with literal expected values cover each requirement.

// File: rtl/swirq_pkg.sv
package swirq_pkg;

  // True when a byte offset is word aligned and names a slot below nharts.
  function automatic logic slot_in_range(input logic [31:0] off, input int unsigned nharts);
    return (off[1:0] == 2'b00) && ({2'b00, off[31:2]} < 32'(nharts));
  endfunction

  // True when a byte offset names exactly hart h.
  function automatic logic slot_is(input logic [31:0] off, input int unsigned h);
    return (off[1:0] == 2'b00) && ({2'b00, off[31:2]} == 32'(h));
  endfunction

endpackage

// File: rtl/swirq_decode.sv
module swirq_decode #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_bit,
  output logic [NUM_HARTS-1:0] slot_hit,
  output logic [NUM_HARTS-1:0] set_req,
  output logic [NUM_HARTS-1:0] wclr_req
);
  import swirq_pkg::*;

  logic [31:0] off;
  assign off = 32'(addr);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    assign slot_hit[h] = sel && slot_is(off, h);
  end

  assign set_req  = slot_hit & {NUM_HARTS{we &  wr_bit}};
  assign wclr_req = slot_hit & {NUM_HARTS{we & ~wr_bit}};

  // R1
  onehot_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));

  // R10
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_in_range(off, NUM_HARTS) |-> (slot_hit == '0));
endmodule

// File: rtl/swirq_pending.sv
module swirq_pending #(
  parameter int NUM_HARTS       = 4,
  parameter bit SUPERVISOR_MODE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_HARTS-1:0] set_req,
  input  logic [NUM_HARTS-1:0] wclr_req,
  input  logic [NUM_HARTS-1:0] hart_clr,
  output logic [NUM_HARTS-1:0] pend
);
  logic [NUM_HARTS-1:0] clr_eff;

  assign clr_eff = SUPERVISOR_MODE ? hart_clr : wclr_req;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend[h] <= 1'b0;
      else if (set_req[h]) pend[h] <= 1'b1;
      else if (clr_eff[h]) pend[h] <= 1'b0;
    end

    // R2
    set_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_req[h] |=> pend[h]);

    // R3
    clear_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_eff[h] && !set_req[h]) |=> !pend[h]);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_req[h] && !clr_eff[h]) |=> $stable(pend[h]));

    if (SUPERVISOR_MODE) begin : g_sup
      // R7
      set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req[h] && hart_clr[h]) |=> pend[h]);
    end else begin : g_mach
      // R8
      clr_pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hart_clr[h] && !set_req[h] && !wclr_req[h]) |=> $stable(pend[h]));
    end
  end
endmodule

// File: rtl/swirq_readmux.sv
module swirq_readmux #(
  parameter int NUM_HARTS       = 4,
  parameter bit SUPERVISOR_MODE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [NUM_HARTS-1:0] slot_hit,
  input  logic [NUM_HARTS-1:0] pend,
  output logic [31:0]          rdata
);
  logic rd_bit;

  assign rd_bit = rd_en && (|(slot_hit & pend));
  assign rdata  = SUPERVISOR_MODE ? 32'h0 : {31'h0, rd_bit};

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:1] == 31'h0);

  // R10
  no_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_hit == '0) |-> (rdata == 32'h0));
endmodule

// File: rtl/swirq_unit.sv
module swirq_unit #(
  parameter int NUM_HARTS       = 4,
  parameter int ADDR_W          = 8,
  parameter bit SUPERVISOR_MODE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_HARTS-1:0] hart_clr,
  output logic [NUM_HARTS-1:0] swi_irq
);
  logic [NUM_HARTS-1:0] slot_hit;
  logic [NUM_HARTS-1:0] set_req;
  logic [NUM_HARTS-1:0] wclr_req;
  logic [NUM_HARTS-1:0] pend;
  logic [30:0]          wdata_unused;

  assign wdata_unused = bus_wdata[31:1];

  swirq_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wr_bit(bus_wdata[0]), .slot_hit(slot_hit), .set_req(set_req), .wclr_req(wclr_req)
  );

  swirq_pending #(.NUM_HARTS(NUM_HARTS), .SUPERVISOR_MODE(SUPERVISOR_MODE)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .wclr_req(wclr_req),
    .hart_clr(hart_clr), .pend(pend)
  );

  swirq_readmux #(.NUM_HARTS(NUM_HARTS), .SUPERVISOR_MODE(SUPERVISOR_MODE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(!bus_we), .slot_hit(slot_hit),
    .pend(pend), .rdata(bus_rdata)
  );

  assign swi_irq = pend;

  // R9
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (swi_irq == '0));

  // R5
  sup_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SUPERVISOR_MODE |-> (bus_rdata == 32'h0));
endmodule

// File: tb/sim_swirq_unit.sv
`timescale 1ns/1ps
module sim_swirq_unit;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [N-1:0]  clr = '0;
  logic [31:0]   rd_m, rd_s;
  logic [N-1:0]  irq_m, irq_s;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int mdl_m [N];
  int mdl_s [N];

  always #2.5 clk = ~clk;

  swirq_unit #(.NUM_HARTS(N), .ADDR_W(AW), .SUPERVISOR_MODE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_m), .hart_clr(clr), .swi_irq(irq_m));

  swirq_unit #(.NUM_HARTS(N), .ADDR_W(AW), .SUPERVISOR_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd_s), .hart_clr(clr), .swi_irq(irq_s));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit addr_ok(input int a);
    return (a % 4 == 0) && (a / 4 < N);
  endfunction

  function automatic logic [N-1:0] pack(input int v [N]);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (v[i] != 0);
    return r;
  endfunction

  // Behavioural reference: one integer per hart and flavour.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mdl_m[i] = 0; mdl_s[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) if (clr[i]) mdl_s[i] = 0;
      if (sel && we && addr_ok(int'(addr))) begin
        if (wdata[0]) begin mdl_m[addr/4] = 1; mdl_s[addr/4] = 1; end
        else mdl_m[addr/4] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R3 model irq machine", 32'(irq_m), 32'(pack(mdl_m)));
      check("R2/R7 model irq supervisor", 32'(irq_s), 32'(pack(mdl_s)));
      if (sel && !we) begin
        check("R4 model read machine", rd_m,
              addr_ok(int'(addr)) ? 32'(mdl_m[addr/4]) : 32'h0);
        check("R5 model read supervisor", rd_s, 32'h0);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [N-1:0] c);
    sel = 1'b1; we = 1'b1; addr = AW'(a); wdata = d; clr = c;
    @(posedge clk); #1;
    sel = 1'b0; we = 1'b0; wdata = '0; clr = '0;
    @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [N-1:0] c);
    clr = c;
    @(posedge clk); #1;
    clr = '0;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string tag, input logic [31:0] em, input logic [31:0] es);
    @(posedge clk); #1;
    sel = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    check({tag, " machine read"}, rd_m, em);
    check({tag, " supervisor read"}, rd_s, es);
    @(posedge clk); #1;
    sel = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset irq machine", 32'(irq_m), 32'h0);
    check("R9 reset irq supervisor", 32'(irq_s), 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;

    wr(32'h04, 32'h1, '0);
    check("R2 set machine", 32'(irq_m), 32'h2);
    check("R2 set supervisor", 32'(irq_s), 32'h2);
    rd(32'h04, "R4 R5", 32'h1, 32'h0);

    wr(32'h04, 32'h0, '0);
    check("R3 clear by write machine", 32'(irq_m), 32'h0);
    check("R6 zero write ignored supervisor", 32'(irq_s), 32'h2);

    wr(32'h08, 32'hFFFF_FFFE, '0);
    check("R11 upper bits ignored machine", 32'(irq_m), 32'h0);
    check("R11 upper bits ignored supervisor", 32'(irq_s), 32'h2);
    wr(32'h08, 32'hFFFF_FFFF, '0);
    check("R11 all-ones sets machine", 32'(irq_m), 32'h4);
    check("R11 all-ones sets supervisor", 32'(irq_s), 32'h6);
    rd(32'h08, "R4 upper read bits zero", 32'h1, 32'h0);

    wr(32'h04, 32'h1, '0);
    pulse_clr(4'b0010);
    check("R7 hart clear supervisor", 32'(irq_s), 32'h4);
    check("R8 hart clear ignored machine", 32'(irq_m), 32'h6);

    wr(32'h08, 32'h1, 4'b0100);
    check("R7 set beats clear supervisor", 32'(irq_s), 32'h4);
    pulse_clr(4'b0100);
    check("R7 clear alone supervisor", 32'(irq_s), 32'h0);
    check("R8 still held machine", 32'(irq_m), 32'h6);

    wr(32'h06, 32'h1, '0);
    wr(32'h10, 32'h1, '0);
    check("R10 bad offsets ignored machine", 32'(irq_m), 32'h6);
    check("R10 bad offsets ignored supervisor", 32'(irq_s), 32'h0);
    rd(32'h10, "R10 beyond range", 32'h0, 32'h0);
    rd(32'h09, "R10 misaligned", 32'h0, 32'h0);
    rd(32'h08, "R4 aligned neighbour", 32'h1, 32'h0);

    wr(32'h0C, 32'h1, '0);
    check("R1 last slot machine", 32'(irq_m), 32'hE);
    check("R1 last slot supervisor", 32'(irq_s), 32'h8);

    @(posedge clk); #1; rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid-run reset machine", 32'(irq_m), 32'h0);
    check("R9 mid-run reset supervisor", 32'(irq_s), 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    rd(32'h0C, "R9 read after reset", 32'h0, 32'h0);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule